// File: doc/BRIEF.md
# USB Input Current Limit Detector

This block decides how much current the charger may draw from a newly attached input source and reports what kind of source it found. When the attach flag rises, the block starts a data-contact-detect wait. The wait is counted in ticks of a slow timebase. When the wait ends, the block classifies the source and places the result on two outputs: a 3-bit current limit code and a 2-bit source-type field. The result then stays fixed for as long as the source stays attached.

A parameter selects one of two variants. The divider variant reads digitized window comparators on D+ and D-, and uses them to recognise three non-standard adapter bias conditions. The select-pin variant reads a select pin and an OTG pin that a USB PHY drives.

The host can request a new detection with a force bit, and an expired watchdog does the same. While that detection runs, the limit is held at 100 mA. When it completes, the block applies the new limit and clears the force bit by itself. Removing the source aborts any detection and returns the block to idle.

Top module: `usb_ilim_detect`

## Requirements
- R1: After reset, and whenever the block is idle, `ilim_o` is 0 (100 mA), `src_type_o` is 2'b00 (unknown), and both `busy_o` and `force_bit_o` are 0. Limit codes are 0=100 mA, 1=500 mA, 2=1 A, 3=2 A, 4=3 A.
- R2: On the clock edge after `attach_i` is seen high in idle, `busy_o` goes to 1 and `ilim_o` reads 0. The result appears on the edge that samples the DCD_TICKS-th `tick_i` pulse after that point. `busy_o` then falls in the same cycle.
- R3: Divider variant: if `dp_in_w1_i`=1 and `dm_in_w1_i`=0, the result is limit 3 (2 A) with source type 2'b10 (adapter).
- R4: Divider variant: if R3 does not match and `dp_in_w2_i`=1, the result is limit 3 with type 2'b10, whatever the D- inputs are.
- R5: Divider variant: if neither R3 nor R4 matches, and `dp_in_w3_i`=0 with `dm_in_w3_i`=1, the result is limit 2 (1 A) with type 2'b10.
- R6: Divider variant: if none of the three conditions matches, the result is limit 1 (500 mA) with type 2'b00.
- R7: Select variant: `sel_i`=1 with `otg_i`=0 gives limit 0 and type 2'b01. `sel_i`=1 with `otg_i`=1 gives limit 1 and type 2'b01. `sel_i`=0 gives limit 4 and type 2'b10.
- R8: Once detection is complete, and while the source stays attached with no force bit and no watchdog pulse, `ilim_o` and `src_type_o` do not change, even when the comparator or pin inputs change.
- R9: A `force_set_i` pulse with the source attached sets `force_bit_o` on the next edge. Once the detection is complete, the bit starts a new detection on the edge after that, and the limit reads 0 while it runs. At completion the new limit is applied and `force_bit_o` returns to 0.
- R10: A `wdt_expire_i` pulse while detection is complete starts a new detection on the next edge, with the same behaviour as R9.
- R11: With `attach_i` low, the next edge returns the block to the R1 values from any state, including in the middle of a detection.
- R12: `src_type_o` never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attach_i | input | 1 | Input source present |
| tick_i | input | 1 | Single-cycle timebase pulse for the contact-detect wait |
| force_set_i | input | 1 | Host write pulse that sets the force bit |
| wdt_expire_i | input | 1 | Watchdog timeout pulse |
| dp_in_w1_i | input | 1 | D+ inside window 1 |
| dm_in_w1_i | input | 1 | D- inside window 1 |
| dp_in_w2_i | input | 1 | D+ inside window 2 |
| dp_in_w3_i | input | 1 | D+ inside window 3 |
| dm_in_w3_i | input | 1 | D- inside window 3 |
| sel_i | input | 1 | Select pin level (select variant) |
| otg_i | input | 1 | OTG pin level (select variant) |
| ilim_o | output | 3 | Input current limit code |
| src_type_o | output | 2 | Source type: 00 unknown, 01 host, 10 adapter |
| busy_o | output | 1 | Detection in progress |
| force_bit_o | output | 1 | Force bit, clears itself at completion |

## Verification
The checker monitors properties on every cycle. It checks that a running detection always shows the 100 mA code and that a detach always lands on the idle values. It also checks that a settled result stays put while attached, that a pending force bit or watchdog pulse restarts detection on the next edge, that the force bit is clear whenever busy falls, and that the reserved source code never appears. Some behaviour only the bench scenarios can show: the exact tick count of the contact-detect wait, the mapping and priority of each divider pattern and pin combination, and the value applied after a forced re-detection.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

  typedef enum logic [2:0] {
    LIM_100MA = 3'd0,
    LIM_500MA = 3'd1,
    LIM_1A    = 3'd2,
    LIM_2A    = 3'd3,
    LIM_3A    = 3'd4
  } ilim_e;

  typedef enum logic [1:0] {
    SRC_UNKNOWN = 2'b00,
    SRC_HOST    = 2'b01,
    SRC_ADAPTER = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } det_state_e;

  typedef struct packed {
    ilim_e lim;
    src_e  src;
  } det_result_t;

  localparam int unsigned VAR_DIVIDER = 0;
  localparam int unsigned VAR_SELECT  = 1;

endpackage

// File: rtl/ilim_dcd_timer.sv
module ilim_dcd_timer #(
  parameter int unsigned DCD_TICKS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (DCD_TICKS > 2) ? $clog2(DCD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DCD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (run_i && tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ilim_classifier.sv
module ilim_classifier
  import ilim_pkg::*;
#(
  parameter int unsigned VARIANT = VAR_DIVIDER
) (
  input  logic        dp_in_w1_i,
  input  logic        dm_in_w1_i,
  input  logic        dp_in_w2_i,
  input  logic        dp_in_w3_i,
  input  logic        dm_in_w3_i,
  input  logic        sel_i,
  input  logic        otg_i,
  output det_result_t result_o
);
  generate
    if (VARIANT == VAR_DIVIDER) begin : g_divider
      logic unused_pins;
      logic hit1, hit2, hit3;
      assign unused_pins = sel_i ^ otg_i;
      assign hit1 = dp_in_w1_i & ~dm_in_w1_i;
      assign hit2 = dp_in_w2_i;
      assign hit3 = ~dp_in_w3_i & dm_in_w3_i;
      always_comb begin
        // fixed priority: divider 1, then 2, then 3
        if (hit1)      result_o = '{lim: LIM_2A,    src: SRC_ADAPTER};
        else if (hit2) result_o = '{lim: LIM_2A,    src: SRC_ADAPTER};
        else if (hit3) result_o = '{lim: LIM_1A,    src: SRC_ADAPTER};
        else           result_o = '{lim: LIM_500MA, src: SRC_UNKNOWN};
      end
    end else begin : g_select
      logic unused_win;
      assign unused_win = ^{dp_in_w1_i, dm_in_w1_i, dp_in_w2_i, dp_in_w3_i, dm_in_w3_i};
      always_comb begin
        if (!sel_i)     result_o = '{lim: LIM_3A,    src: SRC_ADAPTER};
        else if (otg_i) result_o = '{lim: LIM_500MA, src: SRC_HOST};
        else            result_o = '{lim: LIM_100MA, src: SRC_HOST};
      end
    end
  endgenerate
endmodule

// File: rtl/ilim_ctrl.sv
module ilim_ctrl
  import ilim_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        attach_i,
  input  logic        force_set_i,
  input  logic        wdt_expire_i,
  input  logic        expire_i,
  input  det_result_t result_i,
  output logic        tmr_clear_o,
  output logic        tmr_run_o,
  output logic [2:0]  ilim_o,
  output logic [1:0]  src_type_o,
  output logic        busy_o,
  output logic        force_bit_o
);
  det_state_e state_q, state_d;
  ilim_e      lim_q;
  src_e       src_q;
  logic       force_q;
  logic       restart;

  assign restart = (state_q == ST_DONE) && (force_q || wdt_expire_i);

  always_comb begin
    state_d = state_q;
    if (!attach_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_WAIT;
        ST_WAIT: if (expire_i) state_d = ST_DONE;
        ST_DONE: if (restart)  state_d = ST_WAIT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lim_q   <= LIM_100MA;
      src_q   <= SRC_UNKNOWN;
      force_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!attach_i) begin
        lim_q   <= LIM_100MA;
        src_q   <= SRC_UNKNOWN;
        force_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_WAIT: begin
            if (expire_i) begin
              lim_q   <= result_i.lim;
              src_q   <= result_i.src;
              force_q <= 1'b0;
            end else if (force_set_i) begin
              force_q <= 1'b1;
            end
          end
          ST_DONE: begin
            if (restart) lim_q <= LIM_100MA;
            if (force_set_i) force_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign tmr_clear_o = (state_q != ST_WAIT);
  assign tmr_run_o   = (state_q == ST_WAIT);
  assign ilim_o      = lim_q;
  assign src_type_o  = src_q;
  assign busy_o      = (state_q == ST_WAIT);
  assign force_bit_o = force_q;
endmodule

// File: rtl/usb_ilim_detect.sv
module usb_ilim_detect
  import ilim_pkg::*;
#(
  parameter int unsigned VARIANT   = VAR_DIVIDER,
  parameter int unsigned DCD_TICKS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       attach_i,
  input  logic       tick_i,
  input  logic       force_set_i,
  input  logic       wdt_expire_i,
  input  logic       dp_in_w1_i,
  input  logic       dm_in_w1_i,
  input  logic       dp_in_w2_i,
  input  logic       dp_in_w3_i,
  input  logic       dm_in_w3_i,
  input  logic       sel_i,
  input  logic       otg_i,
  output logic [2:0] ilim_o,
  output logic [1:0] src_type_o,
  output logic       busy_o,
  output logic       force_bit_o
);
  det_result_t result;
  logic        expire, tmr_clear, tmr_run;

  ilim_dcd_timer #(.DCD_TICKS(DCD_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tmr_clear),
    .run_i    (tmr_run),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  ilim_classifier #(.VARIANT(VARIANT)) u_class (
    .dp_in_w1_i (dp_in_w1_i),
    .dm_in_w1_i (dm_in_w1_i),
    .dp_in_w2_i (dp_in_w2_i),
    .dp_in_w3_i (dp_in_w3_i),
    .dm_in_w3_i (dm_in_w3_i),
    .sel_i      (sel_i),
    .otg_i      (otg_i),
    .result_o   (result)
  );

  ilim_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .attach_i     (attach_i),
    .force_set_i  (force_set_i),
    .wdt_expire_i (wdt_expire_i),
    .expire_i     (expire),
    .result_i     (result),
    .tmr_clear_o  (tmr_clear),
    .tmr_run_o    (tmr_run),
    .ilim_o       (ilim_o),
    .src_type_o   (src_type_o),
    .busy_o       (busy_o),
    .force_bit_o  (force_bit_o)
  );
endmodule

// File: rtl/ilim_detect_chk.sv
module ilim_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       attach_i,
  input logic       wdt_expire_i,
  input logic [2:0] ilim_o,
  input logic [1:0] src_type_o,
  input logic       busy_o,
  input logic       force_bit_o
);
  a_r2_busy_at_100ma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ilim_o == 3'd0);

  a_r11_detach_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attach_i |=> (!busy_o && !force_bit_o && ilim_o == 3'd0 && src_type_o == 2'b00));

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $past(attach_i)) |-> ($stable(ilim_o) && $stable(src_type_o)));

  a_r9_force_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && force_bit_o && attach_i) |=> busy_o);

  a_r9_force_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !force_bit_o);

  a_r10_wdt_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wdt_expire_i && attach_i) |=> busy_o);

  a_r12_no_reserved_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_type_o != 2'b11);
endmodule

bind usb_ilim_detect ilim_detect_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .attach_i     (attach_i),
  .wdt_expire_i (wdt_expire_i),
  .ilim_o       (ilim_o),
  .src_type_o   (src_type_o),
  .busy_o       (busy_o),
  .force_bit_o  (force_bit_o)
);

// File: tb/sim_usb_ilim_detect.sv
module sim_usb_ilim_detect;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned DCD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic attach = 0, tick = 0, force_set = 0, wdt = 0;
  logic dp1 = 0, dm1 = 0, dp2 = 0, dp3 = 0, dm3 = 0, sel = 0, otg = 0;
  logic [2:0] lim0, lim1;
  logic [1:0] src0, src1;
  logic busy0, busy1, frc0, frc1;
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ilim_detect #(.VARIANT(0), .DCD_TICKS(DCD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .attach_i(attach), .tick_i(tick),
    .force_set_i(force_set), .wdt_expire_i(wdt),
    .dp_in_w1_i(dp1), .dm_in_w1_i(dm1), .dp_in_w2_i(dp2), .dp_in_w3_i(dp3), .dm_in_w3_i(dm3),
    .sel_i(sel), .otg_i(otg),
    .ilim_o(lim0), .src_type_o(src0), .busy_o(busy0), .force_bit_o(frc0));

  usb_ilim_detect #(.VARIANT(1), .DCD_TICKS(DCD)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .attach_i(attach), .tick_i(tick),
    .force_set_i(force_set), .wdt_expire_i(wdt),
    .dp_in_w1_i(dp1), .dm_in_w1_i(dm1), .dp_in_w2_i(dp2), .dp_in_w3_i(dp3), .dm_in_w3_i(dm3),
    .sel_i(sel), .otg_i(otg),
    .ilim_o(lim1), .src_type_o(src1), .busy_o(busy1), .force_bit_o(frc1));

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_once();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_force();
    force_set = 1'b1; @(negedge clk); force_set = 1'b0;
  endtask

  task automatic set_win(input logic a, b, c, d, e);
    dp1 = a; dm1 = b; dp2 = c; dp3 = d; dm3 = e;
  endtask

  task automatic detach();
    attach = 1'b0; cyc(2);
  endtask

  // attach, run the wait, check busy along the way (R2)
  task automatic attach_run();
    attach = 1'b1; @(negedge clk);
    chk("R2 busy after attach", busy0, 1);
    chk("R2 limit 100mA while busy", lim0, 0);
    for (int i = 0; i < DCD - 1; i++) tick_once();
    cyc(2);
    chk("R2 still busy before last tick", busy0, 1);
    tick_once();
    chk("R2 busy low after last tick", busy0, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset limit", lim0, 0);
    chk("R1 reset src", src0, 0);
    chk("R1 reset busy", busy0, 0);
    chk("R1 reset force", frc0, 0);
    pulse_force();
    chk("R1 force ignored in idle", frc0, 0);
  endtask

  task automatic t_div(input string req, input logic a, b, c, d, e, input int el, input int es);
    detach();
    set_win(a, b, c, d, e);
    attach_run();
    chk({req, " limit"}, lim0, el);
    chk({req, " src"}, src0, es);
    chk("R12 src legal", int'(src0 == 2'b11), 0);
  endtask

  task automatic t_sel(input logic s, o, input int el, input int es);
    detach();
    sel = s; otg = o;
    attach_run();
    chk("R7 select limit", lim1, el);
    chk("R7 select src", src1, es);
  endtask

  task automatic t_hold();
    detach();
    set_win(1, 0, 0, 0, 0);
    attach_run();
    set_win(0, 0, 0, 0, 1);
    for (int i = 0; i < DCD + 2; i++) tick_once();
    chk("R8 limit held", lim0, 3);
    chk("R8 busy stays low", busy0, 0);
  endtask

  task automatic t_force();
    // starts from the t_hold result (2 A), inputs now divider 3
    pulse_force();
    chk("R9 force bit set", frc0, 1);
    chk("R9 not yet busy", busy0, 0);
    @(negedge clk);
    chk("R9 redetect busy", busy0, 1);
    chk("R9 limit 100mA during redetect", lim0, 0);
    for (int i = 0; i < DCD; i++) tick_once();
    chk("R9 new limit", lim0, 2);
    chk("R9 force self-clear", frc0, 0);
    chk("R9 idle after redetect", busy0, 0);
  endtask

  task automatic t_wdt();
    set_win(0, 0, 0, 0, 0);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    chk("R10 watchdog busy", busy0, 1);
    chk("R10 limit 100mA", lim0, 0);
    for (int i = 0; i < DCD; i++) tick_once();
    chk("R10 new limit", lim0, 1);
    chk("R10 new src", src0, 0);
  endtask

  task automatic t_detach();
    set_win(0, 0, 1, 0, 0);
    detach();
    attach = 1'b1; @(negedge clk);
    tick_once(); tick_once();
    attach = 1'b0; @(negedge clk);
    chk("R11 abort busy", busy0, 0);
    chk("R11 abort limit", lim0, 0);
    attach_run();
    chk("R11 fresh run after abort", lim0, 3);
    attach = 1'b0; @(negedge clk);
    chk("R11 detach limit", lim0, 0);
    chk("R11 detach src", src0, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_div("R3 divider1", 1, 0, 0, 0, 0, 3, 2);
    t_div("R6 dm in w1 spoils divider1", 1, 1, 0, 0, 0, 1, 0);
    t_div("R4 divider2 dm ignored", 0, 1, 1, 0, 1, 3, 2);
    t_div("R5 divider3", 0, 0, 0, 0, 1, 2, 2);
    t_div("R6 none", 0, 0, 0, 1, 1, 1, 0);
    t_sel(1, 0, 0, 1);
    t_sel(1, 1, 1, 1);
    t_sel(0, 1, 4, 2);
    t_hold();
    t_force();
    t_wdt();
    t_detach();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule